// File: doc/BRIEF.md
# Process-Tag Address Remapping Unit

This block holds a 7-bit process tag and uses it to turn virtual addresses into modified virtual addresses before they reach the caches and TLBs. Addresses whose top seven bits are zero land in one of 128 slots chosen by the tag. Addresses with any of those bits set pass through unchanged. With this scheme, processes that share the low part of the address space no longer alias in virtually indexed storage. The unit has two remapping paths, one for instruction fetch and one for data access. It also has a third path for branch-target lookups, which never applies the tag.

Software reads and writes the tag through a coprocessor-style port. The port selects the tag register by a register number, a secondary register field and a sub-opcode. Every accepted write also sends a one-cycle invalidate pulse to the branch target buffer. This stops entries recorded under one process from being used by another. All outputs are registered. Each address path has one cycle of latency and uses the tag that is held in the cycle the address is presented.

Top module: `pid_remap_unit`

## Requirements
- R1: After synchronous reset the tag is zero, `btb_flush` is low and `cp_rdata` is zero.
- R2: An address presented in cycle t whose bits 31:25 are all zero appears in cycle t+1 on its remap output with bits 31:25 equal to the tag and bits 24:0 unchanged.
- R3: An address whose bits 31:25 are not all zero appears unchanged on its remap output one cycle later.
- R4: The instruction and data paths remap independently and concurrently, each from its own input.
- R5: `btb_addr` equals `btb_va` from the previous cycle and is never modified by the tag.
- R6: A write loads `cp_wdata[31:25]` into the tag. Remapping in the cycle of the write uses the old tag, and the new tag applies from the next cycle on.
- R7: Every accepted write, including one that rewrites the current value, raises `btb_flush` for exactly the following cycle.
- R8: Read data bits 24:0 are always zero, and written values of those bits are discarded.
- R9: Only `cp_crn`=13, `cp_crm`=0 and `cp_op2`=0 select the register. A write with any other encoding leaves the tag unchanged and raises no flush.
- R10: `cp_rdata` is loaded one cycle after a selected read strobe with {tag, 25'b0}. In every other cycle it is loaded with zero, including after a read with a non-matching encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_wr | input | 1 | Register write strobe |
| cp_rd | input | 1 | Register read strobe |
| cp_crn | input | 4 | Coprocessor register number |
| cp_crm | input | 4 | Secondary register field |
| cp_op2 | input | 3 | Sub-opcode |
| cp_wdata | input | 32 | Write data; tag taken from bits 31:25 |
| cp_rdata | output | 32 | Registered read data |
| ifetch_va | input | 32 | Instruction-side virtual address |
| ifetch_mva | output | 32 | Instruction-side modified address |
| data_va | input | 32 | Data-side virtual address |
| data_mva | output | 32 | Data-side modified address |
| btb_va | input | 32 | Branch-target lookup address |
| btb_addr | output | 32 | Branch-target address, never remapped |
| btb_flush | output | 1 | One-cycle branch target buffer invalidate |

## Verification
The assertions check these properties on every cycle:
- The flush follows each decoded write, and no flush occurs without one.
- The tag holds between writes.
- Non-zero-top addresses pass through, and zero-top addresses take the held tag.
- The branch path copies its input.
- The reserved read bits stay zero.

Only the bench scenarios show the remaining behaviour. This covers the ordering between a write and a remap in the same cycle, a rewrite of an unchanged value, and rejected encodings followed by a read. It also covers the value actually returned by a read after a sequence of writes.

// File: rtl/pid_remap_pkg.sv
package pid_remap_pkg;
  localparam int ADDR_W_DEF  = 32;
  localparam int TAG_W_DEF   = 7;
  localparam int CRN_W_DEF   = 4;
  localparam int CRM_W_DEF   = 4;
  localparam int OP2_W_DEF   = 3;
  localparam int SEL_CRN_DEF = 13;
  localparam int SEL_CRM_DEF = 0;
  localparam int SEL_OP2_DEF = 0;

  typedef enum int {
    PATH_IFETCH = 0,
    PATH_DATA   = 1,
    PATH_BTB    = 2
  } path_e;

  localparam int NPATH = 3;
endpackage

// File: rtl/pid_cp_decode.sv
module pid_cp_decode #(
  parameter int CRN_W   = 4,
  parameter int CRM_W   = 4,
  parameter int OP2_W   = 3,
  parameter int SEL_CRN = 13,
  parameter int SEL_CRM = 0,
  parameter int SEL_OP2 = 0
) (
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [CRN_W-1:0] crn,
  input  logic [CRM_W-1:0] crm,
  input  logic [OP2_W-1:0] op2,
  output logic             wr_hit,
  output logic             rd_hit
);
  logic sel;

  always_comb begin
    sel    = (crn == CRN_W'(SEL_CRN)) && (crm == CRM_W'(SEL_CRM)) && (op2 == OP2_W'(SEL_OP2));
    wr_hit = wr_en && sel;
    rd_hit = rd_en && sel;
  end
endmodule

// File: rtl/pid_tag_reg.sv
module pid_tag_reg #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic              rd_hit,
  input  logic [TAG_W-1:0]  wtag,
  output logic [TAG_W-1:0]  tag_q,
  output logic [ADDR_W-1:0] rdata,
  output logic              flush
);
  localparam int LOW_W = ADDR_W - TAG_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
      rdata <= '0;
      flush <= 1'b0;
    end else begin
      flush <= wr_hit;
      rdata <= rd_hit ? {tag_q, {LOW_W{1'b0}}} : '0;
      if (wr_hit) tag_q <= wtag;
    end
  end
endmodule

// File: rtl/pid_addr_remap.sv
module pid_addr_remap #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 7
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] va,
  input  logic [TAG_W-1:0]  tag,
  output logic [ADDR_W-1:0] mva
);
  localparam int LOW_W = ADDR_W - TAG_W;

  logic [TAG_W-1:0]  top;
  logic [ADDR_W-1:0] nxt;

  always_comb begin
    top = va[ADDR_W-1 -: TAG_W];
    nxt = (top == '0) ? {top | tag, va[LOW_W-1:0]} : va;
  end

  always_ff @(posedge clk) mva <= nxt;
endmodule

// File: rtl/pid_remap_unit.sv
module pid_remap_unit
  import pid_remap_pkg::*;
#(
  parameter int ADDR_W  = ADDR_W_DEF,
  parameter int TAG_W   = TAG_W_DEF,
  parameter int CRN_W   = CRN_W_DEF,
  parameter int CRM_W   = CRM_W_DEF,
  parameter int OP2_W   = OP2_W_DEF,
  parameter int SEL_CRN = SEL_CRN_DEF,
  parameter int SEL_CRM = SEL_CRM_DEF,
  parameter int SEL_OP2 = SEL_OP2_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cp_wr,
  input  logic              cp_rd,
  input  logic [CRN_W-1:0]  cp_crn,
  input  logic [CRM_W-1:0]  cp_crm,
  input  logic [OP2_W-1:0]  cp_op2,
  input  logic [ADDR_W-1:0] cp_wdata,
  output logic [ADDR_W-1:0] cp_rdata,
  input  logic [ADDR_W-1:0] ifetch_va,
  output logic [ADDR_W-1:0] ifetch_mva,
  input  logic [ADDR_W-1:0] data_va,
  output logic [ADDR_W-1:0] data_mva,
  input  logic [ADDR_W-1:0] btb_va,
  output logic [ADDR_W-1:0] btb_addr,
  output logic              btb_flush
);
  localparam int LOW_W = ADDR_W - TAG_W;

  logic              wr_hit, rd_hit;
  logic [TAG_W-1:0]  tag_q;
  logic [ADDR_W-1:0] va_arr  [NPATH];
  logic [ADDR_W-1:0] mva_arr [NPATH];
  logic              unused_wlow;

  assign unused_wlow = ^cp_wdata[LOW_W-1:0];

  pid_cp_decode #(
    .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W),
    .SEL_CRN(SEL_CRN), .SEL_CRM(SEL_CRM), .SEL_OP2(SEL_OP2)
  ) u_dec (
    .wr_en(cp_wr), .rd_en(cp_rd), .crn(cp_crn), .crm(cp_crm), .op2(cp_op2),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  pid_tag_reg #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_reg (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .wtag(cp_wdata[ADDR_W-1 -: TAG_W]),
    .tag_q(tag_q), .rdata(cp_rdata), .flush(btb_flush)
  );

  assign va_arr[PATH_IFETCH] = ifetch_va;
  assign va_arr[PATH_DATA]   = data_va;
  assign va_arr[PATH_BTB]    = btb_va;

  for (genvar i = 0; i < NPATH; i++) begin : g_path
    localparam bit HONOR_TAG = (i != PATH_BTB);
    logic [TAG_W-1:0] tag_sel;
    assign tag_sel = HONOR_TAG ? tag_q : '0;
    pid_addr_remap #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_map (
      .clk(clk), .va(va_arr[i]), .tag(tag_sel), .mva(mva_arr[i])
    );
  end

  assign ifetch_mva = mva_arr[PATH_IFETCH];
  assign data_mva   = mva_arr[PATH_DATA];
  assign btb_addr   = mva_arr[PATH_BTB];
endmodule

// File: rtl/pid_remap_chk.sv
module pid_remap_chk #(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 7,
  parameter int CRN_W   = 4,
  parameter int CRM_W   = 4,
  parameter int OP2_W   = 3,
  parameter int SEL_CRN = 13,
  parameter int SEL_CRM = 0,
  parameter int SEL_OP2 = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              cp_wr,
  input logic [CRN_W-1:0]  cp_crn,
  input logic [CRM_W-1:0]  cp_crm,
  input logic [OP2_W-1:0]  cp_op2,
  input logic [ADDR_W-1:0] cp_wdata,
  input logic [ADDR_W-1:0] cp_rdata,
  input logic [ADDR_W-1:0] ifetch_va,
  input logic [ADDR_W-1:0] ifetch_mva,
  input logic [ADDR_W-1:0] data_va,
  input logic [ADDR_W-1:0] data_mva,
  input logic [ADDR_W-1:0] btb_va,
  input logic [ADDR_W-1:0] btb_addr,
  input logic              btb_flush,
  input logic [TAG_W-1:0]  tag_q
);
  localparam int LOW_W = ADDR_W - TAG_W;

  logic wr_sel;
  assign wr_sel = cp_wr && (cp_crn == CRN_W'(SEL_CRN)) &&
                  (cp_crm == CRM_W'(SEL_CRM)) && (cp_op2 == OP2_W'(SEL_OP2));

  p_flush_r7: assert property (@(posedge clk) disable iff (rst) wr_sel |=> btb_flush);
  p_noflush_r9: assert property (@(posedge clk) disable iff (rst) !wr_sel |=> !btb_flush);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst) !wr_sel |=> $stable(tag_q));
  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    wr_sel |=> tag_q == $past(cp_wdata[ADDR_W-1 -: TAG_W]));
  p_ipass_r3: assert property (@(posedge clk) disable iff (rst)
    (ifetch_va[ADDR_W-1 -: TAG_W] != '0) |=> ifetch_mva == $past(ifetch_va));
  p_dpass_r3: assert property (@(posedge clk) disable iff (rst)
    (data_va[ADDR_W-1 -: TAG_W] != '0) |=> data_mva == $past(data_va));
  p_dslot_r2: assert property (@(posedge clk) disable iff (rst)
    (data_va[ADDR_W-1 -: TAG_W] == '0) |=>
      data_mva == {$past(tag_q), $past(data_va[LOW_W-1:0])});
  p_islot_r4: assert property (@(posedge clk) disable iff (rst)
    (ifetch_va[ADDR_W-1 -: TAG_W] == '0) |=>
      ifetch_mva == {$past(tag_q), $past(ifetch_va[LOW_W-1:0])});
  p_btb_r5: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> btb_addr == $past(btb_va));
  p_rsvd_r8: assert property (@(posedge clk) disable iff (rst) cp_rdata[LOW_W-1:0] == '0);
endmodule

bind pid_remap_unit pid_remap_chk #(
  .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W),
  .SEL_CRN(SEL_CRN), .SEL_CRM(SEL_CRM), .SEL_OP2(SEL_OP2)
) u_chk (
  .clk(clk), .rst(rst), .cp_wr(cp_wr), .cp_crn(cp_crn), .cp_crm(cp_crm),
  .cp_op2(cp_op2), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
  .ifetch_va(ifetch_va), .ifetch_mva(ifetch_mva), .data_va(data_va),
  .data_mva(data_mva), .btb_va(btb_va), .btb_addr(btb_addr),
  .btb_flush(btb_flush), .tag_q(tag_q)
);

// File: tb/test_pid_remap_unit.sv
module test_pid_remap_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cp_wr = 0, cp_rd = 0;
  logic [3:0]  cp_crn = 0, cp_crm = 0;
  logic [2:0]  cp_op2 = 0;
  logic [31:0] cp_wdata = 0, ifetch_va = 0, data_va = 0, btb_va = 0;
  logic [31:0] cp_rdata, ifetch_mva, data_mva, btb_addr;
  logic        btb_flush;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [6:0] model_tag = '0;

  typedef struct {
    logic        flush;
    logic [31:0] rdata, imva, dmva, baddr;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  pid_remap_unit i_pid_remap_unit (
    .clk(clk), .rst(rst), .cp_wr(cp_wr), .cp_rd(cp_rd), .cp_crn(cp_crn),
    .cp_crm(cp_crm), .cp_op2(cp_op2), .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
    .ifetch_va(ifetch_va), .ifetch_mva(ifetch_mva), .data_va(data_va),
    .data_mva(data_mva), .btb_va(btb_va), .btb_addr(btb_addr), .btb_flush(btb_flush)
  );

  function automatic logic [31:0] model_map(logic [31:0] va, logic [6:0] tag);
    if (va[31:25] == 7'd0) return {tag, va[24:0]};
    return va;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(bit wr, bit rd, logic [3:0] crn, logic [3:0] crm, logic [2:0] op2,
                       logic [31:0] wd, logic [31:0] iva, logic [31:0] dva, logic [31:0] bva);
    exp_t e;
    bit sel;
    @(negedge clk);
    cp_wr = wr; cp_rd = rd; cp_crn = crn; cp_crm = crm; cp_op2 = op2;
    cp_wdata = wd; ifetch_va = iva; data_va = dva; btb_va = bva;
    sel = (crn == 4'd13) && (crm == 4'd0) && (op2 == 3'd0);
    e.flush = wr && sel;
    e.rdata = (rd && sel) ? {model_tag, 25'd0} : 32'd0;
    e.imva  = model_map(iva, model_tag);
    e.dmva  = model_map(dva, model_tag);
    e.baddr = bva;
    sb.push_back(e);
    if (wr && sel) model_tag = wd[31:25];
  endtask

  task automatic wr_tag(logic [31:0] wd);
    drive(1, 0, 13, 0, 0, wd, 32'h0000_1000, 32'h0000_2000, 32'h0000_3000);
  endtask

  task automatic rd_tag();
    drive(0, 1, 13, 0, 0, 0, 32'h0100_0040, 32'h0000_0080, 32'h0000_00C0);
  endtask

  // Scoreboard monitor: one expected item per clock edge after reset
  always @(posedge clk) begin
    if (!rst) begin
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check("R7/R9 flush", {31'd0, btb_flush}, {31'd0, e.flush});
        check("R10/R8 rdata", cp_rdata, e.rdata);
        check("R2/R3/R6 ifetch", ifetch_mva, e.imva);
        check("R4/R6 data", data_mva, e.dmva);
        check("R5 btb", btb_addr, e.baddr);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R1: reset state
    check("R1 flush", {31'd0, btb_flush}, 32'd0);
    check("R1 rdata", cp_rdata, 32'd0);
    rd_tag();                                        // R1: tag reads zero
    drive(0, 0, 0, 0, 0, 0, 32'h0012_3456, 32'h01FF_FFFF, 32'h0000_0004); // R2 with tag 0
    // R6/R8: write with junk in reserved bits; same-cycle remap uses old tag
    wr_tag(32'hB5FF_FFFF);
    drive(0, 0, 0, 0, 0, 0, 32'h0000_0010, 32'h0123_4567, 32'hFFFF_FFFF); // R6: new tag
    rd_tag();                                        // R10/R8
    // R3: passthrough on both paths
    drive(0, 0, 0, 0, 0, 0, 32'h0200_0000, 32'h8000_0001, 32'h0000_0000);
    drive(0, 0, 0, 0, 0, 0, 32'hFE00_0000, 32'h0000_0000, 32'h1234_5678); // R4 mixed
    // R7: rewrite same value, back-to-back writes
    wr_tag(32'hB400_0000);
    wr_tag(32'hB400_0000);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R9: rejected encodings, then read back
    drive(1, 0, 12, 0, 0, 32'h0200_0000, 32'h0000_0001, 32'h0000_0002, 0);
    drive(1, 0, 13, 1, 0, 32'h0400_0000, 32'h0000_0001, 32'h0000_0002, 0);
    drive(1, 0, 13, 0, 1, 32'h0600_0000, 32'h0000_0001, 32'h0000_0002, 0);
    drive(0, 1, 13, 0, 4, 0, 0, 0, 0);               // R10: non-matching read -> zero
    rd_tag();
    // write and read in the same cycle: read returns old value
    drive(1, 1, 13, 0, 0, 32'hFE00_0000, 32'h0000_0005, 32'h0000_0006, 0);
    rd_tag();
    wr_tag(32'h0000_0000);                           // back to tag 0
    drive(0, 0, 0, 0, 0, 0, 32'h0000_0007, 32'h0000_0008, 0);
    // mixed pattern sweep
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b, c, w;
      a = $urandom; b = $urandom; c = $urandom; w = $urandom;
      if (k % 2 == 0) a[31:25] = 7'd0;
      if (k % 3 == 0) b[31:25] = 7'd0;
      drive((k % 7) == 0, (k % 5) == 0, ((k % 11) == 0) ? 4'd12 : 4'd13,
            ((k % 13) == 0) ? 4'd2 : 4'd0, 3'd0, w, a, b, c);
    end
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 scoreboard drained", sb.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule